// File: doc/BRIEF.md
# Codec register access decoder

This block sits behind the receive side of a serial audio link. Once a frame has been received and split into fields, it looks at the frame's tag bits, its command-address slot and its command-data slot, and decides whether the frame carries a register read or write meant for this codec. A write goes into a small array of 16-bit registers and is also announced on a one-cycle strobe with its index and data. A read is turned into a pending response with index and data, which the transmitter places in the next outgoing frame.

The codec's own ID comes from board straps. The acceptance rules change with that ID. ID 0 is the primary device and expects the slot-valid tags to be set. IDs 1 to 3 are secondary devices, which only answer frames whose slot 1 and slot 2 valid tags are both clear, because for them a nonzero codec ID in the frame is what marks the address as valid. Every decision is made on the single cycle in which `frame_done` is high. Nothing is accepted while the codec-ready flag is low.

Top module: `codec_reg_access`

## Requirements
- R1: A synchronous active-high reset clears `wr_stb`, `rd_pending` and `rd_idx`, and `rd_data` reads 0x0000 after reset.
- R2: A write is a frame with the read/write flag (slot 1 bit 19) at 0, the index in slot 1 bits 18:12 and the data in slot 2 bits 19:4. When the write is accepted, `wr_stb` is high for exactly the one cycle after `frame_done`, `wr_idx` and `wr_data` carry the index and data, and the register keeps the data for later reads.
- R3: A read is a frame with the read/write flag at 1. When the read is accepted, `rd_pending` rises in the cycle after `frame_done`, `rd_idx` holds the index and `rd_data` holds the register's current value.
- R4: For own ID 0, a read needs the slot 1 valid tag set, and a write needs both the slot 1 and slot 2 valid tags set in the same frame. A frame with slot 1 valid set, slot 2 valid clear and the flag at 0 does nothing.
- R5: For own ID 1, 2 or 3, a read or write is accepted only when the slot 1 and slot 2 valid tags are both clear. Any other tag combination is ignored.
- R6: A frame is ignored when its frame-valid tag is clear or when its 2-bit codec ID differs from `own_id`.
- R7: A frame with index bit 0 set is ignored for both reads and writes.
- R8: Every frame is ignored while `codec_ready` is low.
- R9: Only word indices below NUM_REGS are implemented (with the default, even indices 0x00 to 0x1E). A read of any other even index returns 0x0000. A write to one raises no strobe and changes nothing.
- R10: A pending response keeps its index and data until `rsp_sent` is pulsed, which clears `rd_pending` in the next cycle. A new accepted read replaces a response that is still pending.
- R11: The field inputs have no effect in cycles where `frame_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_done | input | 1 | One-cycle strobe: the field inputs hold a complete received frame |
| codec_ready | input | 1 | Codec ready; while low, all accesses are ignored |
| own_id | input | 2 | Strap-selected codec ID (0 is primary) |
| tag_frame_valid | input | 1 | Frame-valid tag bit |
| tag_slot1_valid | input | 1 | Slot 1 valid tag bit |
| tag_slot2_valid | input | 1 | Slot 2 valid tag bit |
| tag_codec_id | input | 2 | Codec ID carried in the frame tag |
| slot1_field | input | 20 | Command-address slot: flag, index, zero padding |
| slot2_field | input | 20 | Command-data slot: write data in bits 19:4 |
| rsp_sent | input | 1 | Pulse from the transmitter once the pending response has been sent |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_idx | output | 7 | Index of the write |
| wr_data | output | 16 | Data of the write |
| rd_pending | output | 1 | A read response is waiting to be sent |
| rd_idx | output | 7 | Index to echo in the response |
| rd_data | output | 16 | Data to return in the response |

## Verification
Every result of a frame is due on the clock edge that samples `frame_done`. The strobe, the pending flag and the response fields all come from one register stage, so each check samples on the falling edge that follows that rising edge. The end of the strobe and the clearing by `rsp_sent` each take one further edge and are sampled one falling edge later. The sweep covers every combination of readiness, the three tag bits, the frame codec ID and the flag, for each of the four strap IDs, over an index that walks through implemented and unimplemented words. Directed frames then cover odd indices, a read that replaces a pending one, a response held over idle cycles, and fields presented without `frame_done`.

// File: rtl/codec_reg_pkg.sv
package codec_reg_pkg;
  parameter int SLOT_W = 20;
  parameter int IDX_W  = 7;
  parameter int DATA_W = 16;
  parameter int ID_W   = 2;

  localparam logic [ID_W-1:0] PRIMARY_ID = '0;

  typedef struct packed {
    logic              rd;
    logic              wr;
    logic              impl;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
  } access_t;
endpackage

// File: rtl/cra_qualify.sv
module cra_qualify
  import codec_reg_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic              fire,
  input  logic              ready,
  input  logic              fv,
  input  logic              s1v,
  input  logic              s2v,
  input  logic [ID_W-1:0]   tag_id,
  input  logic [ID_W-1:0]   own_id,
  input  logic [SLOT_W-1:0] s1,
  input  logic [SLOT_W-1:0] s2,
  output access_t           acc
);
  localparam int PAD1_W = SLOT_W - 1 - IDX_W;
  localparam int PAD2_W = SLOT_W - DATA_W;

  logic              is_read;
  logic [IDX_W-1:0]  idx;
  logic              addressed;
  logic              primary;
  logic              rd_tags_ok;
  logic              wr_tags_ok;
  logic              in_range;
  logic              unused_pad;

  assign is_read    = s1[SLOT_W-1];
  assign idx        = s1[SLOT_W-2 -: IDX_W];
  assign unused_pad = ^{s1[PAD1_W-1:0], s2[PAD2_W-1:0]};

  always_comb begin
    primary    = (own_id == PRIMARY_ID);
    addressed  = fire & ready & fv & (tag_id == own_id) & ~idx[0];
    rd_tags_ok = primary ? s1v : (~s1v & ~s2v);
    wr_tags_ok = primary ? (s1v & s2v) : (~s1v & ~s2v);
    in_range   = (int'(idx[IDX_W-1:1]) < NUM_REGS);

    acc.rd   = addressed & is_read & rd_tags_ok;
    acc.wr   = addressed & ~is_read & wr_tags_ok & in_range;
    acc.impl = in_range;
    acc.idx  = idx;
    acc.data = s2[SLOT_W-1 -: DATA_W];
  end
endmodule

// File: rtl/cra_regfile.sv
module cra_regfile #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 16,
  localparam int ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cra_read_queue.sv
module cra_read_queue #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] load_idx,
  input  logic             load_impl,
  input  logic             sent,
  output logic             pending,
  output logic [IDX_W-1:0] idx,
  output logic             impl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      idx     <= '0;
      impl    <= 1'b0;
    end else if (load) begin
      pending <= 1'b1;
      idx     <= load_idx;
      impl    <= load_impl;
    end else if (sent) begin
      pending <= 1'b0;
    end
  end
endmodule

// File: rtl/codec_reg_access.sv
module codec_reg_access
  import codec_reg_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_done,
  input  logic              codec_ready,
  input  logic [ID_W-1:0]   own_id,
  input  logic              tag_frame_valid,
  input  logic              tag_slot1_valid,
  input  logic              tag_slot2_valid,
  input  logic [ID_W-1:0]   tag_codec_id,
  input  logic [SLOT_W-1:0] slot1_field,
  input  logic [SLOT_W-1:0] slot2_field,
  input  logic              rsp_sent,
  output logic              wr_stb,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_pending,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  localparam int ADDR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  access_t           acc;
  logic [DATA_W-1:0] ram_q;
  logic              rd_impl;

  cra_qualify #(.NUM_REGS(NUM_REGS)) u_qual (
    .fire   (frame_done),
    .ready  (codec_ready),
    .fv     (tag_frame_valid),
    .s1v    (tag_slot1_valid),
    .s2v    (tag_slot2_valid),
    .tag_id (tag_codec_id),
    .own_id (own_id),
    .s1     (slot1_field),
    .s2     (slot2_field),
    .acc    (acc)
  );

  cra_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_regs (
    .clk   (clk),
    .we    (acc.wr),
    .waddr (acc.idx[ADDR_W:1]),
    .wdata (acc.data),
    .re    (acc.rd & acc.impl),
    .raddr (acc.idx[ADDR_W:1]),
    .rdata (ram_q)
  );

  cra_read_queue #(.IDX_W(IDX_W)) u_rdq (
    .clk       (clk),
    .rst       (rst),
    .load      (acc.rd),
    .load_idx  (acc.idx),
    .load_impl (acc.impl),
    .sent      (rsp_sent),
    .pending   (rd_pending),
    .idx       (rd_idx),
    .impl      (rd_impl)
  );

  assign rd_data = rd_impl ? ram_q : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_stb  <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= acc.wr;
      if (acc.wr) begin
        wr_idx  <= acc.idx;
        wr_data <= acc.data;
      end
    end
  end
endmodule

// File: rtl/codec_reg_access_chk.sv
module codec_reg_access_chk
  import codec_reg_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_done,
  input logic              codec_ready,
  input logic [ID_W-1:0]   own_id,
  input logic              tag_frame_valid,
  input logic              tag_slot1_valid,
  input logic              tag_slot2_valid,
  input logic              rsp_sent,
  input logic              wr_stb,
  input logic [IDX_W-1:0]  wr_idx,
  input logic              rd_pending,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [DATA_W-1:0] rd_data
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!wr_stb && !rd_pending));

  p_read_from_frame_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_pending) |-> $past(frame_done && codec_ready && tag_frame_valid));

  p_write_needs_ready_r8: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> $past(frame_done && codec_ready && tag_frame_valid));

  p_secondary_tags_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && $past(own_id) != PRIMARY_ID) |-> $past(!tag_slot1_valid && !tag_slot2_valid));

  p_primary_tags_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && $past(own_id) == PRIMARY_ID) |-> $past(tag_slot1_valid && tag_slot2_valid));

  p_even_index_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_stb |-> !wr_idx[0]) and (rd_pending |-> !rd_idx[0]));

  p_unimpl_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_pending && int'(rd_idx[IDX_W-1:1]) >= NUM_REGS) |-> (rd_data == '0));

  p_hold_pending_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_pending && !rsp_sent && !frame_done) |=>
      (rd_pending && $stable(rd_idx) && $stable(rd_data)));

  p_sent_clears_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_pending && rsp_sent && !frame_done) |=> !rd_pending);

  p_idle_no_write_r11: assert property (@(posedge clk) disable iff (rst)
    !frame_done |=> !wr_stb);
endmodule

bind codec_reg_access codec_reg_access_chk #(.NUM_REGS(NUM_REGS)) u_chk (.*);

// File: tb/codec_reg_access_test.sv
module codec_reg_access_test;
  localparam int NREG = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_done = 1'b0;
  logic        codec_ready = 1'b0;
  logic [1:0]  own_id = 2'd0;
  logic        tag_frame_valid = 1'b0;
  logic        tag_slot1_valid = 1'b0;
  logic        tag_slot2_valid = 1'b0;
  logic [1:0]  tag_codec_id = 2'd0;
  logic [19:0] slot1_field = '0;
  logic [19:0] slot2_field = '0;
  logic        rsp_sent = 1'b0;
  logic        wr_stb;
  logic [6:0]  wr_idx;
  logic [15:0] wr_data;
  logic        rd_pending;
  logic [6:0]  rd_idx;
  logic [15:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [15:0] model [NREG];

  always #2 clk = ~clk;

  codec_reg_access #(.NUM_REGS(NREG)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] id);
    @(negedge clk);
    rst = 1'b1; own_id = id;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 wr_stb", {31'd0, wr_stb}, 0);
    chk("R1 rd_pending", {31'd0, rd_pending}, 0);
    chk("R1 rd_data", {16'd0, rd_data}, 0);
  endtask

  // Presents one frame with frame_done high for one cycle; returns at the
  // falling edge after the capturing rising edge.
  task automatic send(input logic rdy, input logic fv, input logic s1v, input logic s2v,
                      input logic [1:0] id, input logic rw, input logic [6:0] idx,
                      input logic [15:0] d);
    @(negedge clk);
    codec_ready = rdy; tag_frame_valid = fv; tag_slot1_valid = s1v;
    tag_slot2_valid = s2v; tag_codec_id = id;
    slot1_field = {rw, idx, 12'h000};
    slot2_field = {d, 4'h0};
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
  endtask

  task automatic release_rsp();
    rsp_sent = 1'b1;
    @(negedge clk);
    rsp_sent = 1'b0;
    chk("R10 cleared by rsp_sent", {31'd0, rd_pending}, 0);
  endtask

  task automatic apply(input string req, input logic rdy, input logic fv, input logic s1v,
                       input logic s2v, input logic [1:0] id, input logic rw,
                       input logic [6:0] idx, input logic [15:0] d);
    logic hit, erd, ewr, impl;
    impl = (int'(idx[6:1]) < NREG);
    hit  = rdy && fv && (id == own_id) && !idx[0];
    if (own_id == 2'd0) begin
      erd = hit && rw && s1v;
      ewr = hit && !rw && s1v && s2v && impl;
    end else begin
      erd = hit && rw && !s1v && !s2v;
      ewr = hit && !rw && !s1v && !s2v && impl;
    end
    send(rdy, fv, s1v, s2v, id, rw, idx, d);
    chk({req, " write strobe"}, {31'd0, wr_stb}, {31'd0, ewr});
    if (ewr) begin
      chk({req, " R2 wr_idx"}, {25'd0, wr_idx}, {25'd0, idx});
      chk({req, " R2 wr_data"}, {16'd0, wr_data}, {16'd0, d});
      model[idx[4:1]] = d;
    end
    chk({req, " read pending"}, {31'd0, rd_pending}, {31'd0, erd});
    if (erd) begin
      chk({req, " R3 rd_idx"}, {25'd0, rd_idx}, {25'd0, idx});
      chk({req, " R3/R9 rd_data"}, {16'd0, rd_data},
          {16'd0, impl ? model[idx[4:1]] : 16'h0000});
      release_rsp();
    end
  endtask

  initial begin
    int n = 0;
    do_reset(2'd0);

    // R2: fill every implemented register, primary device
    for (int w = 0; w < NREG; w++)
      apply("R2 init", 1, 1, 1, 1, 2'd0, 0, 7'(w * 2), 16'hC000 + 16'(w * 16'h0111));
    // wr_stb lasts one cycle
    send(1, 1, 1, 1, 2'd0, 0, 7'h04, 16'h5A5A);
    model[2] = 16'h5A5A;
    @(negedge clk);
    chk("R2 strobe single cycle", {31'd0, wr_stb}, 0);

    // Sweep: every strap ID, every tag / readiness / flag combination (R3-R6, R8, R9)
    for (int o = 0; o < 4; o++) begin
      do_reset(2'(o));
      for (int c = 0; c < 128; c++) begin
        logic [6:0] ix;
        ix = 7'(((n * 3) % 20) * 2);
        apply((c[5:4] != o[1:0]) ? "R6" : (!c[6] ? "R8" : (o == 0 ? "R4" : "R5")),
              c[6], c[0], c[1], c[2], c[5:4], c[3], ix, 16'h1234 + 16'(n * 16'h0101));
        n++;
      end
    end

    // R7: odd index ignored for reads and writes on a primary device
    do_reset(2'd0);
    apply("R7 odd write", 1, 1, 1, 1, 2'd0, 0, 7'h05, 16'hDEAD);
    apply("R7 odd read", 1, 1, 1, 0, 2'd0, 1, 7'h03, 16'h0000);
    apply("R7 check reg", 1, 1, 1, 0, 2'd0, 1, 7'h04, 16'h0000);

    // R9: unimplemented read returns zero; write has no strobe
    apply("R9 unimpl write", 1, 1, 1, 1, 2'd0, 0, 7'h40, 16'hBEEF);
    apply("R9 unimpl read", 1, 1, 1, 0, 2'd0, 1, 7'h40, 16'h0000);

    // R10: newer read replaces pending one; held over idle cycles
    send(1, 1, 1, 0, 2'd0, 1, 7'h02, 16'h0);
    chk("R10 first read", {25'd0, rd_idx}, 7'h02);
    send(1, 1, 1, 0, 2'd0, 1, 7'h06, 16'h0);
    chk("R10 replaced idx", {25'd0, rd_idx}, 7'h06);
    chk("R10 replaced data", {16'd0, rd_data}, {16'd0, model[3]});
    repeat (5) @(negedge clk);
    chk("R10 still pending", {31'd0, rd_pending}, 1);
    chk("R10 held idx", {25'd0, rd_idx}, 7'h06);
    release_rsp();

    // R11: valid fields without frame_done do nothing
    @(negedge clk);
    codec_ready = 1; tag_frame_valid = 1; tag_slot1_valid = 1; tag_slot2_valid = 1;
    tag_codec_id = 2'd0; slot1_field = {1'b0, 7'h08, 12'h000}; slot2_field = {16'hFFFF, 4'h0};
    repeat (3) @(negedge clk);
    chk("R11 no strobe", {31'd0, wr_stb}, 0);
    chk("R11 no pending", {31'd0, rd_pending}, 0);
    apply("R11 reg unchanged", 1, 1, 1, 0, 2'd0, 1, 7'h08, 16'h0000);

    // Read back every register as secondary device 3
    do_reset(2'd3);
    for (int w = 0; w < NREG; w++)
      apply("R5 readback", 1, 1, 0, 0, 2'd3, 1, 7'(w * 2), 16'h0000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule